// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects interrupt requests from a parameterized set of sources and decides whether to raise an interrupt to the CPU. It also chooses the vector address the CPU should fetch. Each source has three register bits:

- a sticky pending flag, set by a one-cycle pulse from the source;
- an enable;
- a priority select.

A global mode bit chooses between two behaviours:

- **Single-level mode.** Every unmasked source vectors to one address. The low-numbered core sources need only the main enable. The remaining peripheral sources also need the secondary enable.
- **Two-level mode.** High priority sources pass through the main enable and go to the high vector. Low priority sources pass through both the main enable and the secondary enable, and go to the low vector.

The main enable always gates everything. Clearing it silences every source in either mode.

When the CPU accepts an interrupt by pulsing `irq_ack`, the block clears the enable that guarded that interrupt. This stops re-entry until software sets the enable again. A consequence is that a high priority request can still interrupt a low priority routine, but a low priority request cannot interrupt a high priority one.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq`, `gie_hi`, `gie_lo`, `two_level`, `flags`, `enables` and `prios` are all 0, and `vector` is 0.
- R2: A flag bit is set by a one-cycle `src_set` pulse and stays set until the matching `flag_clr` bit is asserted. When a set pulse and a clear land in the same cycle, the flag ends up set.
- R3: A source can request only when both its flag and its enable are 1. A set flag with a cleared enable never raises `irq`.
- R4: With `two_level`=0, a requesting core source (index below NCORE) raises `irq` when `gie_hi`=1. A requesting peripheral source (index NCORE and up) also needs `gie_lo`=1. The vector is 0x0008 in both cases.
- R5: While `gie_hi`=0, `irq` is 0 in both modes, whatever the priority, enable, flag and `gie_lo` values.
- R6: With `two_level`=1, a requesting source whose priority bit is 1 raises `irq` when `gie_hi`=1, regardless of `gie_lo`, with vector 0x0008.
- R7: With `two_level`=1, a requesting source whose priority bit is 0 raises `irq` only when `gie_hi`=1 and `gie_lo`=1, with vector 0x0018.
- R8: When high and low priority requests are present together in two-level mode, the vector is 0x0008.
- R9: An `irq_ack` while `irq`=1 with vector 0x0008 clears `gie_hi` on the next cycle. With vector 0x0018 it clears `gie_lo` instead and leaves `gie_hi` unchanged.
- R10: An `irq_ack` while `irq`=0 changes no enable. An accepted acknowledge wins over a software write of 1 to the same enable in the same cycle.
- R11: While a low priority interrupt is in service (`gie_lo` cleared by acknowledge), a new high priority request still raises `irq`. After a high priority acknowledge, a pending low priority request does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Write strobe for the mode bit |
| mode_wd | input | 1 | Mode bit value, 1 = two-level |
| ghi_we | input | 1 | Write strobe for the main enable |
| ghi_wd | input | 1 | Main enable value |
| glo_we | input | 1 | Write strobe for the secondary enable |
| glo_wd | input | 1 | Secondary enable value |
| en_we | input | 1 | Write strobe for the per-source enables |
| en_wd | input | NSRC | Per-source enable values |
| pri_we | input | 1 | Write strobe for the per-source priorities |
| pri_wd | input | NSRC | Per-source priority values, 1 = high |
| flag_clr | input | NSRC | Per-source flag clear, one cycle |
| src_set | input | NSRC | Per-source flag set pulse, one cycle |
| irq_ack | input | 1 | CPU acceptance of the current interrupt |
| irq | output | 1 | Interrupt request to the CPU |
| vector | output | AW | Vector address, 0 when idle |
| two_level | output | 1 | Current mode bit |
| gie_hi | output | 1 | Main enable |
| gie_lo | output | 1 | Secondary enable |
| flags | output | NSRC | Pending flags |
| enables | output | NSRC | Per-source enables |
| prios | output | NSRC | Per-source priorities |

## Verification
The bench targets the following corner cases:

- **Set and clear in the same cycle.** A design that let the clear win would silently lose an event.
- **Main enable cleared while low priority work is pending in two-level mode.** A design that gated only high requests on the main enable would still interrupt here.
- **Acknowledge of a low priority interrupt.** A design that cleared the main enable instead would block the preemption that R11 demands.
- **Acknowledge with nothing pending.** A design that acted on it would drop an enable.
- **Acknowledge in the same cycle as a software re-enable.** A design that let the write win would allow immediate re-entry.

Both sources requesting at once also shows whether the high vector is given priority over the low one.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NSRC = 8,
  parameter int NCORE = 3,
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_HI = 'h0008,
  parameter logic [AW-1:0] VEC_LO = 'h0018
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_we,
  input  logic            mode_wd,
  input  logic            ghi_we,
  input  logic            ghi_wd,
  input  logic            glo_we,
  input  logic            glo_wd,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_wd,
  input  logic            pri_we,
  input  logic [NSRC-1:0] pri_wd,
  input  logic [NSRC-1:0] flag_clr,
  input  logic [NSRC-1:0] src_set,
  input  logic            irq_ack,
  output logic            irq,
  output logic [AW-1:0]   vector,
  output logic            two_level,
  output logic            gie_hi,
  output logic            gie_lo,
  output logic [NSRC-1:0] flags,
  output logic [NSRC-1:0] enables,
  output logic [NSRC-1:0] prios
);

  logic [NSRC-1:0] core_mask;
  for (genvar i = 0; i < NSRC; i++) begin : g_core
    assign core_mask[i] = (i < NCORE);
  end

  logic [NSRC-1:0] req;
  logic core_req, per_req, hi_req, lo_req, fire_hi, fire_lo, take;

  assign req      = flags & enables;
  assign core_req = |(req & core_mask);
  assign per_req  = |(req & ~core_mask);
  assign hi_req   = |(req & prios);
  assign lo_req   = |(req & ~prios);

  assign fire_hi = two_level ? (gie_hi & hi_req)
                             : (gie_hi & (core_req | (gie_lo & per_req)));
  assign fire_lo = two_level & gie_hi & gie_lo & lo_req;

  assign irq    = fire_hi | fire_lo;
  assign vector = fire_hi ? VEC_HI : (fire_lo ? VEC_LO : '0);
  assign take   = irq_ack & irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      two_level <= 1'b0;
      gie_hi    <= 1'b0;
      gie_lo    <= 1'b0;
      flags     <= '0;
      enables   <= '0;
      prios     <= '0;
    end else begin
      if (mode_we) two_level <= mode_wd;
      if (take && fire_hi)    gie_hi <= 1'b0;
      else if (ghi_we)        gie_hi <= ghi_wd;
      if (take && !fire_hi)   gie_lo <= 1'b0;
      else if (glo_we)        gie_lo <= glo_wd;
      if (en_we)  enables <= en_wd;
      if (pri_we) prios   <= pri_wd;
      flags <= src_set | (flags & ~flag_clr);
    end
  end

  // R2: a set pulse always lands, even against a clear
  a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((flags & $past(src_set)) == $past(src_set)));

  // R5: main enable off silences everything
  a_r5_hi_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_hi |-> !irq);

  // R7: low vector only in two-level mode with the secondary enable on
  a_r7_lo_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && vector == VEC_LO) |-> (two_level && gie_lo));

  // R9: acknowledge of a high/legacy interrupt drops the main enable
  a_r9_ack_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq && vector == VEC_HI) |=> !gie_hi);

  // R9: acknowledge of a low interrupt drops only the secondary enable
  a_r9_ack_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq && vector == VEC_LO && !ghi_we) |=> (!gie_lo && gie_hi));

  // R10: acknowledge with nothing pending leaves the main enable alone
  a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq && !ghi_we) |=> (gie_hi == $past(gie_hi)));

endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int NSRC = 8;
  localparam int NCORE = 3;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_we = 0, mode_wd = 0, ghi_we = 0, ghi_wd = 0, glo_we = 0, glo_wd = 0;
  logic en_we = 0, pri_we = 0, irq_ack = 0;
  logic [NSRC-1:0] en_wd = '0, pri_wd = '0, flag_clr = '0, src_set = '0;
  logic irq, two_level, gie_hi, gie_lo;
  logic [AW-1:0] vector;
  logic [NSRC-1:0] flags, enables, prios;

  always #2 clk = ~clk;

  irq_prio_ctrl #(.NSRC(NSRC), .NCORE(NCORE), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_wd(mode_wd),
    .ghi_we(ghi_we), .ghi_wd(ghi_wd),
    .glo_we(glo_we), .glo_wd(glo_wd),
    .en_we(en_we), .en_wd(en_wd),
    .pri_we(pri_we), .pri_wd(pri_wd),
    .flag_clr(flag_clr), .src_set(src_set),
    .irq_ack(irq_ack),
    .irq(irq), .vector(vector),
    .two_level(two_level), .gie_hi(gie_hi), .gie_lo(gie_lo),
    .flags(flags), .enables(enables), .prios(prios)
  );

  int total = 0;
  int fails = 0;
  string tag = "R1";

  bit m_mode, m_gh, m_gl;
  bit [NSRC-1:0] m_f, m_e, m_p;

  function automatic void model_out(output bit hi, output bit lo);
    hi = 0; lo = 0;
    for (int i = 0; i < NSRC; i++) begin
      if (m_f[i] && m_e[i] && m_gh) begin
        if (m_mode) begin
          if (m_p[i]) hi = 1;
          else if (m_gl) lo = 1;
        end else if (i < NCORE || m_gl) hi = 1;
      end
    end
  endfunction

  always @(posedge clk) begin
    bit hi, lo;
    if (!rst_n) begin
      m_mode = 0; m_gh = 0; m_gl = 0; m_f = '0; m_e = '0; m_p = '0;
    end else begin
      model_out(hi, lo);
      if (mode_we) m_mode = mode_wd;
      if (irq_ack && hi) m_gh = 0;
      else if (ghi_we) m_gh = ghi_wd;
      if (irq_ack && lo && !hi) m_gl = 0;
      else if (glo_we) m_gl = glo_wd;
      if (en_we) m_e = en_wd;
      if (pri_we) m_p = pri_wd;
      for (int i = 0; i < NSRC; i++)
        if (src_set[i]) m_f[i] = 1;
        else if (flag_clr[i]) m_f[i] = 0;
    end
  end

  task automatic chk(string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit hi, lo;
    model_out(hi, lo);
    chk("irq", irq, hi | lo);
    chk("vector", vector, hi ? 16'h0008 : (lo ? 16'h0018 : 16'h0000));
    chk("gie_hi", gie_hi, m_gh);
    chk("gie_lo", gie_lo, m_gl);
    chk("two_level", two_level, m_mode);
    chk("flags", flags, m_f);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    mode_we = 0; ghi_we = 0; glo_we = 0; en_we = 0; pri_we = 0;
    irq_ack = 0; src_set = '0; flag_clr = '0;
  endtask

  initial begin
    #(200000 * 4);
    fails++; total++;
    $display("FAIL watchdog expired at %s", tag);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    compare_all();
    chk("enables", enables, 0);
    chk("prios", prios, 0);
    rst_n = 1;
    tick();

    tag = "R3";
    ghi_we = 1; ghi_wd = 1; glo_we = 1; glo_wd = 1; src_set = 8'h01; tick();
    chk("R3 no irq without enable", irq, 0);
    en_we = 1; en_wd = 8'hFF; tick();
    chk("R3 irq with enable", irq, 1);
    chk("R4 legacy vector", vector, 16'h0008);

    tag = "R2";
    src_set = 8'h01; flag_clr = 8'h01; tick();
    chk("R2 set beats clear", flags[0], 1);
    flag_clr = 8'h01; tick();
    chk("R2 cleared", flags[0], 0);
    tick();
    chk("R2 stays cleared", flags[0], 0);

    tag = "R4";
    glo_we = 1; glo_wd = 0; src_set = 8'h20; tick();
    chk("R4 peripheral blocked", irq, 0);
    glo_we = 1; glo_wd = 1; tick();
    chk("R4 peripheral fires", irq, 1);
    flag_clr = 8'h20; src_set = 8'h02; glo_we = 1; glo_wd = 0; tick();
    chk("R4 core needs only main", irq, 1);

    tag = "R5";
    ghi_we = 1; ghi_wd = 0; glo_we = 1; glo_wd = 1; tick();
    chk("R5 legacy off", irq, 0);
    mode_we = 1; mode_wd = 1; pri_we = 1; pri_wd = 8'h20; src_set = 8'h40; tick();
    chk("R5 two-level off", irq, 0);
    flag_clr = 8'hFF; ghi_we = 1; ghi_wd = 1; glo_we = 1; glo_wd = 0; tick();

    tag = "R6";
    src_set = 8'h20; tick();
    chk("R6 high fires", irq, 1);
    chk("R6 high vector", vector, 16'h0008);
    flag_clr = 8'h20; tick();

    tag = "R7";
    src_set = 8'h40; tick();
    chk("R7 low blocked", irq, 0);
    glo_we = 1; glo_wd = 1; tick();
    chk("R7 low vector", vector, 16'h0018);

    tag = "R8";
    src_set = 8'h20; tick();
    chk("R8 high wins", vector, 16'h0008);

    tag = "R9";
    irq_ack = 1; tick();
    chk("R9 main cleared", gie_hi, 0);
    chk("R9 secondary kept", gie_lo, 1);
    ghi_we = 1; ghi_wd = 1; flag_clr = 8'h20; tick();
    irq_ack = 1; tick();
    chk("R9 secondary cleared", gie_lo, 0);
    chk("R9 main kept", gie_hi, 1);

    tag = "R11";
    src_set = 8'h20; tick();
    chk("R11 high preempts", irq, 1);
    irq_ack = 1; tick();
    glo_we = 1; glo_wd = 1; tick();
    chk("R11 low cannot preempt", irq, 0);

    tag = "R10";
    irq_ack = 1; tick();
    chk("R10 idle ack keeps main", gie_hi, 0);
    chk("R10 idle ack keeps secondary", gie_lo, 1);
    ghi_we = 1; ghi_wd = 1; tick();
    irq_ack = 1; ghi_we = 1; ghi_wd = 1; tick();
    chk("R10 ack beats write", gie_hi, 0);
    tick();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule